// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is one programmable event counter for the performance monitor of an I/O address-translation unit. Each clock cycle the translation pipeline may present an event strobe. The strobe carries a 15-bit event code and the context of the transaction that caused it. The context holds a device identifier, a process identifier with its own valid flag, a guest context identifier and a process context identifier. The counter holds a 64-bit selector register and a 64-bit count register. The count advances by one only when the event code matches the programmed code and the transaction context passes every filter that the selector enables.

Events come in as a plain valid strobe. The counter accepts every strobe in the cycle it arrives and never applies back-pressure, so the pipeline needs no ready signal. The selector and the count are written through plain write-enable ports, and both values are read back on output buses. The counter drives its own bit of the shared overflow-status register and a one-cycle interrupt request. Bus decode and the cycle counter belong to neighbouring logic.

Selector layout, which the filters decode:

| Bits | Field |
|------|-------|
| 14:0 | event code |
| 15 | range-mask mode |
| 35:16 | process field |
| 59:36 | device field |
| 60 | process-match enable |
| 61 | device-match enable |
| 62 | identifier-type select |
| 63 | overflow flag |

Top module: `pmu_event_counter`

## Requirements
- R1: After reset, the selector, the count, the overflow-status bit and the interrupt output are all zero.
- R2: A selector write stores the written word as given, except for the event code in bits 14:0. If the written code is 0, or is at or above `EVT_ID_LIMIT` (default 20), bits 14:0 are stored as 0. An event code of 0 in the selector never counts, even when the incoming code is also 0.
- R3: A strobe counts only if `ev_valid` is 1, the incoming `ev_id` equals selector bits 14:0, and that field is non-zero.
- R4: While `inhibit` is 1, no strobe changes the count.
- R5: Bit 62 chooses which identifiers the filters use. When it is 1, the device filter uses `ctx_gscid` and the process filter uses `ctx_pscid`. When it is 0, they use `ctx_dev_id` and `ctx_pid`.
- R6: When bit 60 is 1 and `ctx_pid_valid` is 1, the chosen process identifier must equal selector bits 35:16. When `ctx_pid_valid` is 0, this check is skipped.
- R7: When bit 61 is 1, the chosen device identifier is compared with selector bits 59:36. If bit 15 is 0, every bit is compared. If bit 15 is 1, the trailing ones of the programmed value and the first zero above them are ignored, and only the bits above that zero are compared.
- R8: A counting strobe while the count is all ones wraps the count to 0. If the status bit was 0, it becomes 1, selector bit 63 becomes 1, and `ovf_irq` is high for exactly the following cycle. If the status bit was already 1, nothing beyond the wrap happens.
- R9: A selector write with bit 63 at 0 clears the status bit, unless an overflow that sets it happens in the same cycle.
- R10: A count write loads `cnt_wr_data` and takes priority over a counting strobe in the same cycle. Such a cycle cannot overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr_en | input | 1 | Selector write strobe |
| sel_wr_data | input | 64 | Selector write value |
| sel_q | output | 64 | Selector contents |
| cnt_wr_en | input | 1 | Count write strobe |
| cnt_wr_data | input | 64 | Count write value |
| cnt_q | output | 64 | Count value |
| inhibit | input | 1 | This counter's bit of the count-inhibit register |
| ev_valid | input | 1 | Event strobe, always accepted |
| ev_id | input | 15 | Event code |
| ctx_dev_id | input | 24 | Transaction device identifier |
| ctx_pid | input | 20 | Transaction process identifier |
| ctx_pid_valid | input | 1 | Process identifier is present |
| ctx_gscid | input | 24 | Guest context identifier |
| ctx_pscid | input | 20 | Process context identifier |
| ovf_status | output | 1 | This counter's bit of the overflow-status register |
| ovf_irq | output | 1 | One-cycle overflow interrupt request |

## Verification
The filters are tried with matching and non-matching event codes, with a code of 0 on both sides, and with the inhibit bit set. These patterns separate code matching from gating. The identifier-type select is exercised by presenting contexts where only the guest pair or only the device pair fits the selector. The process-filter cases use strobes with and without a valid process identifier. The range mask is checked with device identifiers just inside and just outside the ignored low bits, and again with the mask mode off. The overflow cases start from a count written near all ones, overflow twice with the status still set, and then clear the status through a selector write.

// File: rtl/pmu_evt_pkg.sv
package pmu_evt_pkg;
  localparam int EID_W = 15;
  localparam int PID_W = 20;
  localparam int DID_W = 24;
  localparam int SEL_W = 64;
  // field positions decoded by the filter
  localparam int EID_LSB  = 0;
  localparam int MASK_BIT = EID_LSB + EID_W;
  localparam int PID_LSB  = MASK_BIT + 1;
  localparam int DID_LSB  = PID_LSB + PID_W;
  localparam int PV_BIT   = DID_LSB + DID_W;
  localparam int DV_BIT   = PV_BIT + 1;
  localparam int IDT_BIT  = DV_BIT + 1;
  localparam int OF_BIT   = IDT_BIT + 1;

  typedef struct packed {
    logic [DID_W-1:0] dev_id;
    logic [PID_W-1:0] pid;
    logic             pid_valid;
    logic [DID_W-1:0] gscid;
    logic [PID_W-1:0] pscid;
  } evt_ctx_t;
endpackage

// File: rtl/pmu_evt_selector.sv
module pmu_evt_selector
  import pmu_evt_pkg::*;
#(
  parameter int EVT_ID_LIMIT = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_data,
  input  logic             set_of,
  output logic [SEL_W-1:0] sel
);
  logic [EID_W-1:0] wr_eid;
  logic             eid_ok;
  logic [SEL_W-1:0] legal;

  always_comb begin
    wr_eid = wr_data[EID_LSB +: EID_W];
    eid_ok = (wr_eid != '0) && (int'(wr_eid) < EVT_ID_LIMIT);
    legal  = wr_data;
    if (!eid_ok) legal[EID_LSB +: EID_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      sel <= '0;
    else if (wr_en)  sel <= legal;
    else if (set_of) sel[OF_BIT] <= 1'b1;
  end

  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (sel[EID_LSB +: EID_W] == '0) ||
              (int'(sel[EID_LSB +: EID_W]) < EVT_ID_LIMIT));
endmodule

// File: rtl/pmu_evt_filter.sv
module pmu_evt_filter
  import pmu_evt_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             ev_valid,
  input  logic [EID_W-1:0] ev_id,
  input  evt_ctx_t         ctx,
  input  logic             inhibit,
  output logic             hit
);
  logic [EID_W-1:0] sel_eid;
  logic [DID_W-1:0] sel_did, did, dmask;
  logic [PID_W-1:0] sel_pid, pid;
  logic             code_ok, pid_ok, did_ok;

  always_comb begin
    sel_eid = sel[EID_LSB +: EID_W];
    sel_did = sel[DID_LSB +: DID_W];
    sel_pid = sel[PID_LSB +: PID_W];
    did     = sel[IDT_BIT] ? ctx.gscid : ctx.dev_id;
    pid     = sel[IDT_BIT] ? ctx.pscid : ctx.pid;
    code_ok = ev_valid && (sel_eid != '0) && (ev_id == sel_eid);
    pid_ok  = !sel[PV_BIT] || !ctx.pid_valid || (pid == sel_pid);
    dmask   = sel[MASK_BIT] ? ~(sel_did ^ (sel_did + 1'b1)) : '1;
    did_ok  = !sel[DV_BIT] || ((did & dmask) == (sel_did & dmask));
    hit     = code_ok && !inhibit && pid_ok && did_ok;
  end
endmodule

// File: rtl/pmu_event_counter.sv
module pmu_event_counter
  import pmu_evt_pkg::*;
#(
  parameter int EVT_ID_LIMIT = 20,
  parameter int CNT_W        = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr_en,
  input  logic [63:0]      sel_wr_data,
  output logic [63:0]      sel_q,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  output logic [CNT_W-1:0] cnt_q,
  input  logic             inhibit,
  input  logic             ev_valid,
  input  logic [14:0]      ev_id,
  input  logic [23:0]      ctx_dev_id,
  input  logic [19:0]      ctx_pid,
  input  logic             ctx_pid_valid,
  input  logic [23:0]      ctx_gscid,
  input  logic [19:0]      ctx_pscid,
  output logic             ovf_status,
  output logic             ovf_irq
);
  evt_ctx_t ctx;
  logic     hit, wrap, new_ovf;

  assign ctx = '{dev_id: ctx_dev_id, pid: ctx_pid, pid_valid: ctx_pid_valid,
                 gscid: ctx_gscid, pscid: ctx_pscid};

  pmu_evt_filter u_filter (
    .sel(sel_q), .ev_valid(ev_valid), .ev_id(ev_id), .ctx(ctx),
    .inhibit(inhibit), .hit(hit)
  );

  assign wrap    = hit && !cnt_wr_en && (&cnt_q);
  assign new_ovf = wrap && !ovf_status;

  pmu_evt_selector #(.EVT_ID_LIMIT(EVT_ID_LIMIT)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(sel_wr_en), .wr_data(sel_wr_data),
    .set_of(new_ovf), .sel(sel_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      ovf_status <= 1'b0;
      ovf_irq    <= 1'b0;
    end else begin
      if (cnt_wr_en) cnt_q <= cnt_wr_data;
      else if (hit)  cnt_q <= cnt_q + 1'b1;
      if (new_ovf)                              ovf_status <= 1'b1;
      else if (sel_wr_en && !sel_wr_data[OF_BIT]) ovf_status <= 1'b0;
      ovf_irq <= new_ovf;
    end
  end

  a_r4_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !cnt_wr_en) |=> cnt_q == $past(cnt_q));
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> cnt_q == $past(cnt_wr_data));
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr_en |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq);
  a_r8_irq_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ovf_status);
  a_r9_status_only_by_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_status) |-> ovf_irq);
endmodule

// File: tb/pmu_event_counter_tb.sv
module pmu_event_counter_tb;
  localparam int LIMIT = 20;
  logic        clk = 0, rst_n = 0;
  logic        sel_wr_en = 0, cnt_wr_en = 0, inhibit = 0, ev_valid = 0, ctx_pid_valid = 0;
  logic [63:0] sel_wr_data = 0, cnt_wr_data = 0, sel_q, cnt_q;
  logic [14:0] ev_id = 0;
  logic [23:0] ctx_dev_id = 0, ctx_gscid = 0;
  logic [19:0] ctx_pid = 0, ctx_pscid = 0;
  logic        ovf_status, ovf_irq;

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";
  logic [63:0] m_sel = 0, m_cnt = 0;
  bit m_stat = 0, m_irq = 0;

  always #10 clk = ~clk;

  pmu_event_counter #(.EVT_ID_LIMIT(LIMIT)) u_dut (.*);

  function automatic bit model_hit();
    logic [23:0] prog, did;
    logic [19:0] pid;
    int t;
    if (!ev_valid || inhibit) return 0;
    if (m_sel[14:0] == 0 || ev_id != m_sel[14:0]) return 0;
    did = m_sel[62] ? ctx_gscid : ctx_dev_id;
    pid = m_sel[62] ? ctx_pscid : ctx_pid;
    if (m_sel[60] && ctx_pid_valid && m_sel[35:16] != pid) return 0;
    if (m_sel[61]) begin
      prog = m_sel[59:36];
      t = -1;
      if (m_sel[15]) begin
        t = 0;
        while (t < 24 && prog[t]) t++;
      end
      for (int i = 0; i < 24; i++)
        if (i > t && prog[i] != did[i]) return 0;
    end
    return 1;
  endfunction

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    bit h, wrap, nirq;
    logic [63:0] n_sel;
    h = model_hit();
    wrap = h && !cnt_wr_en && (&m_cnt);
    nirq = wrap && !m_stat;
    n_sel = m_sel;
    if (sel_wr_en) begin
      n_sel = sel_wr_data;
      if (sel_wr_data[14:0] == 0 || sel_wr_data[14:0] >= LIMIT) n_sel[14:0] = 0;
    end else if (nirq) n_sel[63] = 1;
    if (nirq) m_stat = 1;
    else if (sel_wr_en && !sel_wr_data[63]) m_stat = 0;
    m_cnt = cnt_wr_en ? cnt_wr_data : (h ? m_cnt + 1 : m_cnt);
    m_sel = n_sel;
    m_irq = nirq;
    @(posedge clk);
    @(negedge clk);
    check("sel", sel_q, m_sel);
    check("cnt", cnt_q, m_cnt);
    check("status", {63'b0, ovf_status}, {63'b0, m_stat});
    check("irq", {63'b0, ovf_irq}, {63'b0, m_irq});
    sel_wr_en = 0; cnt_wr_en = 0; ev_valid = 0;
  endtask

  task automatic wsel(logic [63:0] v);
    sel_wr_en = 1; sel_wr_data = v; tick();
  endtask
  task automatic wcnt(logic [63:0] v);
    cnt_wr_en = 1; cnt_wr_data = v; tick();
  endtask
  task automatic ev(logic [14:0] id, logic [23:0] dev, logic [19:0] pid, bit pv,
                    logic [23:0] gs, logic [19:0] ps);
    ev_valid = 1; ev_id = id; ctx_dev_id = dev; ctx_pid = pid; ctx_pid_valid = pv;
    ctx_gscid = gs; ctx_pscid = ps; tick();
  endtask

  function automatic logic [63:0] mk(bit idt, bit dv, bit pv, logic [23:0] d,
                                     logic [19:0] p, bit msk, logic [14:0] id);
    return {1'b0, idt, dv, pv, d, p, msk, id};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    check("sel", sel_q, 0); check("cnt", cnt_q, 0);
    check("status", {63'b0, ovf_status}, 0); check("irq", {63'b0, ovf_irq}, 0);

    cur_req = "R2";
    wsel(mk(0,0,0,24'h5,20'h7,0,15'd0));
    wsel(mk(0,0,0,0,0,0,15'd20));
    wsel(mk(0,0,0,0,0,0,15'd25));
    ev(15'd0, 0, 0, 0, 0, 0);
    wsel(mk(0,0,0,0,0,0,15'd19));
    wsel(mk(0,0,0,0,0,0,15'd3));

    cur_req = "R3";
    ev(15'd3, 0, 0, 0, 0, 0);
    ev(15'd4, 0, 0, 0, 0, 0);
    ev(15'd3, 0, 0, 0, 0, 0);
    tick();

    cur_req = "R4";
    inhibit = 1; ev(15'd3, 0, 0, 0, 0, 0); inhibit = 0;
    ev(15'd3, 0, 0, 0, 0, 0);

    cur_req = "R5";
    wsel(mk(1,1,0,24'h0000AB,0,0,15'd3));
    ev(15'd3, 24'h0000AB, 0, 0, 24'h000001, 0);
    ev(15'd3, 24'h000001, 0, 0, 24'h0000AB, 0);
    wsel(mk(0,1,0,24'h0000AB,0,0,15'd3));
    ev(15'd3, 24'h0000AB, 0, 0, 24'h000001, 0);

    cur_req = "R6";
    wsel(mk(0,0,1,0,20'h123,0,15'd3));
    ev(15'd3, 0, 20'h123, 1, 0, 0);
    ev(15'd3, 0, 20'h124, 1, 0, 0);
    ev(15'd3, 0, 20'h124, 0, 0, 0);
    wsel(mk(1,0,1,0,20'h55,0,15'd3));
    ev(15'd3, 0, 20'h55, 1, 0, 20'h56);
    ev(15'd3, 0, 20'h56, 1, 0, 20'h55);

    cur_req = "R7";
    wsel(mk(0,1,0,24'h000013,0,1,15'd3));
    ev(15'd3, 24'h000014, 0, 0, 0, 0);
    ev(15'd3, 24'h000010, 0, 0, 0, 0);
    ev(15'd3, 24'h000018, 0, 0, 0, 0);
    wsel(mk(0,1,0,24'hFFFFFF,0,1,15'd3));
    ev(15'd3, 24'h123456, 0, 0, 0, 0);
    wsel(mk(0,1,0,24'h000013,0,0,15'd3));
    ev(15'd3, 24'h000014, 0, 0, 0, 0);
    ev(15'd3, 24'h000013, 0, 0, 0, 0);

    cur_req = "R10";
    wsel(mk(0,0,0,0,0,0,15'd3));
    cnt_wr_en = 1; cnt_wr_data = 64'h10; ev(15'd3, 0, 0, 0, 0, 0);
    cnt_wr_en = 1; cnt_wr_data = '1; ev(15'd3, 0, 0, 0, 0, 0);

    cur_req = "R8";
    ev(15'd3, 0, 0, 0, 0, 0);
    tick();
    wcnt('1);
    ev(15'd3, 0, 0, 0, 0, 0);

    cur_req = "R9";
    wsel(mk(0,0,0,0,0,0,15'd3) | 64'h8000_0000_0000_0000);
    wsel(mk(0,0,0,0,0,0,15'd3));
    wcnt('1);
    ev(15'd3, 0, 0, 0, 0, 0);
    tick();

    cur_req = "R8";
    wcnt('1);
    sel_wr_en = 1; sel_wr_data = mk(0,0,0,0,0,0,15'd3);
    ev(15'd3, 0, 0, 0, 0, 0);
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected <5000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule